// File: doc/BRIEF.md
# Boot-Mode Copy and Remap Engine

This block decides, during reset, what the processor finds at the bottom of its address space. Two strap pins are sampled while reset is asserted. When both are low, the block selects flash-copy boot. It keeps the processor in reset and pulls the first 4096 bytes of a byte-serial flash stream into a 4 KB on-chip SRAM. It then maps that SRAM at address zero and lets the processor run. Any other strap value selects direct-execute boot. In that mode the SRAM stays hidden, the low window is routed to an external read-only memory port, and the processor is released almost at once.

The processor side is a byte-wide port with an address, a read strobe and a write strobe. Read data appears one cycle after the strobe. The low window covers addresses below 2^27. Every address at or above 0x0800_0000 falls outside it and reads as zero. The flash side is a plain valid/ready byte stream. The external memory side is a chip-select, an address and a read-data bus.

Top module: `boot_remap_top`

## Requirements
- R1: Strap value 2'b00 on `mode_pins` selects flash-copy boot. The values 2'b01, 2'b10 and 2'b11 select direct-execute boot.
- R2: The straps are captured only while `rst_n` is low. Pin changes after reset release have no effect until the next reset.
- R3: In flash-copy boot, while bytes are still being copied, `cpu_rst_n` is low, `boot_busy` is high and `boot_done` is low.
- R4: Flash byte k (k = 0..4095, in stream order) is stored at SRAM offset k. A byte is accepted only on a clock edge where `nf_valid` and `nf_ready` are both high. Gaps in `nf_valid` neither skip nor repeat a byte.
- R5: After the edge that accepts byte 4095, `boot_done` is high and `boot_busy` and `nf_ready` are low. `cpu_rst_n` rises on the following edge.
- R6: After flash-copy boot, a CPU read of addresses 0x000..0xFFF returns the SRAM byte one cycle after `cpu_rd`. A CPU write to those addresses updates the byte.
- R7: After flash-copy boot, reads in the window above 0xFFF return zero, and `nor_cs_n` stays high throughout flash-copy boot.
- R8: In direct-execute boot, `boot_done` is high one cycle after reset release and `cpu_rst_n` is high two cycles after it. `boot_busy` and `nf_ready` never rise.
- R9: In direct-execute boot, a CPU read in the window drives `nor_cs_n` low with `nor_addr` equal to the low 27 address bits. `cpu_rdata` then carries `nor_rdata` one cycle later.
- R10: In direct-execute boot, CPU writes are dropped: `nor_cs_n` stays high during the write and later reads return unchanged external contents.
- R11: In both modes, reads at or above address 0x0800_0000 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| mode_pins | input | 2 | Boot-mode strap pins |
| cpu_rst_n | output | 1 | Active-low reset to the processor |
| boot_busy | output | 1 | High while the flash copy runs |
| boot_done | output | 1 | High once the boot mapping is final |
| nf_data | input | 8 | Flash stream byte |
| nf_valid | input | 1 | Flash stream byte valid |
| nf_ready | output | 1 | Engine accepts a flash byte |
| cpu_addr | input | 32 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, valid one cycle after the strobe |
| nor_cs_n | output | 1 | External memory chip select, active low |
| nor_addr | output | 27 | External memory byte address |
| nor_rdata | input | 8 | External memory read byte |

## Verification
The flash stream is fed with a regular pattern of valid gaps plus one long stall in the middle. All 4096 SRAM bytes are then read back through the CPU port. This catches an engine that counts on valid alone, since it would shift or duplicate bytes. The exact release cycle is checked to find a design that lets the processor run early or one cycle late. The straps are flipped after reset in both modes to expose a latch that keeps tracking the pins. Writes in direct-execute mode are watched at the chip select, reads above 0xFFF and outside the window must return zero, and a decoder that leaks into the external port or aliases the SRAM would fail those checks.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
    typedef enum logic {
        BOOT_DIRECT = 1'b0,
        BOOT_COPY   = 1'b1
    } boot_mode_e;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_COPY  = 2'd1,
        ST_RUN   = 2'd2
    } copy_state_e;
endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_remap_pkg::*;
#(
    parameter int PIN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins,
    output boot_mode_e       mode
);
    boot_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!rst_n) begin
            mode_d = (pins == '0) ? BOOT_COPY : BOOT_DIRECT;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R2: once out of reset the captured mode never moves
    p_mode_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/boot_copy_ctrl.sv
module boot_copy_ctrl
    import boot_remap_pkg::*;
#(
    parameter int SRAM_BYTES = 4096,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(SRAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  boot_mode_e        mode,
    input  logic [DATA_W-1:0] nf_data,
    input  logic              nf_valid,
    output logic              nf_ready,
    output logic              busy,
    output logic              done,
    output logic              cpu_run,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SRAM_BYTES - 1);

    typedef struct packed {
        copy_state_e      state;
        logic [IDX_W-1:0] cnt;
        logic             run;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  take;

    always_comb begin
        ctrl_d = ctrl_q;
        take   = (ctrl_q.state == ST_COPY) && nf_valid;
        unique case (ctrl_q.state)
            ST_START: ctrl_d.state = (mode == BOOT_COPY) ? ST_COPY : ST_RUN;
            ST_COPY: begin
                if (take) begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    if (ctrl_q.cnt == LAST_IDX) begin
                        ctrl_d.state = ST_RUN;
                    end
                end
            end
            default: ctrl_d.state = ST_RUN;
        endcase
        ctrl_d.run = (ctrl_q.state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_START, cnt: '0, run: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign nf_ready = (ctrl_q.state == ST_COPY);
    assign busy     = (ctrl_q.state == ST_COPY);
    assign done     = (ctrl_q.state == ST_RUN);
    assign cpu_run  = ctrl_q.run;
    assign wr_en    = take;
    assign wr_idx   = ctrl_q.cnt;
    assign wr_data  = nf_data;

    // R3: processor stays in reset for the whole copy
    p_cpu_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_run);
    // R4: no byte is counted without a valid beat
    p_no_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !nf_valid) |=> $stable(ctrl_q.cnt));
    // R5: release only follows a finished mapping
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> $past(done));
    // R8: direct boot never requests flash bytes
    p_no_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BOOT_DIRECT) |-> !nf_ready);
endmodule

// File: rtl/boot_addr_map.sv
module boot_addr_map
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 8,
    parameter int WIN_BITS   = 27,
    parameter int SRAM_BYTES = 4096,
    localparam int IDX_W     = $clog2(SRAM_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  boot_mode_e          mode,
    input  logic                cpu_run,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    input  logic                fill_en,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic [DATA_W-1:0]   fill_data,
    output logic                nor_cs_n,
    output logic [WIN_BITS-1:0] nor_addr,
    input  logic [DATA_W-1:0]   nor_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } map_t;

    map_t              map_d, map_q;
    logic [DATA_W-1:0] sram [SRAM_BYTES];
    logic              in_win, in_sram, nor_sel, sram_rd, sram_wr;
    logic [IDX_W-1:0]  cpu_idx;

    always_comb begin
        in_win  = (cpu_addr[ADDR_W-1:WIN_BITS] == '0);
        in_sram = in_win && (cpu_addr[WIN_BITS-1:IDX_W] == '0);
        cpu_idx = cpu_addr[IDX_W-1:0];
        nor_sel = cpu_run && (mode == BOOT_DIRECT) && in_win && cpu_rd;
        sram_rd = cpu_run && (mode == BOOT_COPY) && in_sram && cpu_rd;
        sram_wr = cpu_run && (mode == BOOT_COPY) && in_sram && cpu_wr;
        map_d.rdata = '0;
        if (nor_sel) begin
            map_d.rdata = nor_rdata;
        end else if (sram_rd) begin
            map_d.rdata = sram[cpu_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            sram[fill_idx] <= fill_data;
        end else if (sram_wr) begin
            sram[cpu_idx] <= cpu_wdata;
        end
    end

    assign cpu_rdata = map_q.rdata;
    assign nor_cs_n  = !nor_sel;
    assign nor_addr  = cpu_addr[WIN_BITS-1:0];

    // R10: a write never selects the external memory
    p_nor_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> nor_cs_n);
    // R7: copy boot never touches the external memory
    p_no_cs_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BOOT_COPY) |-> nor_cs_n);
    // R11: an out-of-window read yields zero on the next cycle
    p_outside_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !in_win) |=> (cpu_rdata == '0));
endmodule

// File: rtl/boot_remap_top.sv
module boot_remap_top
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 8,
    parameter int WIN_BITS   = 27,
    parameter int SRAM_BYTES = 4096,
    parameter int PIN_W      = 2,
    localparam int IDX_W     = $clog2(SRAM_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PIN_W-1:0]    mode_pins,
    output logic                cpu_rst_n,
    output logic                boot_busy,
    output logic                boot_done,
    input  logic [DATA_W-1:0]   nf_data,
    input  logic                nf_valid,
    output logic                nf_ready,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                nor_cs_n,
    output logic [WIN_BITS-1:0] nor_addr,
    input  logic [DATA_W-1:0]   nor_rdata
);
    boot_mode_e        mode;
    logic              run;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [DATA_W-1:0] fill_data;

    boot_strap_latch #(.PIN_W(PIN_W)) u_strap (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (mode_pins),
        .mode (mode)
    );

    boot_copy_ctrl #(.SRAM_BYTES(SRAM_BYTES), .DATA_W(DATA_W)) u_copy (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .nf_data (nf_data),
        .nf_valid(nf_valid),
        .nf_ready(nf_ready),
        .busy    (boot_busy),
        .done    (boot_done),
        .cpu_run (run),
        .wr_en   (fill_en),
        .wr_idx  (fill_idx),
        .wr_data (fill_data)
    );

    boot_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .SRAM_BYTES(SRAM_BYTES)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cpu_run  (run),
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_data(fill_data),
        .nor_cs_n (nor_cs_n),
        .nor_addr (nor_addr),
        .nor_rdata(nor_rdata)
    );

    assign cpu_rst_n = run;
endmodule

// File: tb/test_boot_remap_top.sv
`timescale 1ns/1ps
module test_boot_remap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b00;
    logic        cpu_rst_n, boot_busy, boot_done, nf_ready;
    logic [7:0]  nf_data = '0;
    logic        nf_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        nor_cs_n;
    logic [26:0] nor_addr;
    logic [7:0]  nor_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    boot_remap_top i_boot_remap_top (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .cpu_rst_n(cpu_rst_n), .boot_busy(boot_busy), .boot_done(boot_done),
        .nf_data(nf_data), .nf_valid(nf_valid), .nf_ready(nf_ready),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .nor_cs_n(nor_cs_n), .nor_addr(nor_addr), .nor_rdata(nor_rdata)
    );

    function automatic logic [7:0] ext_byte(logic [26:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] flash_byte(int i);
        logic [31:0] v;
        v = (i * 37) ^ (i >> 4) ^ 32'hC3;
        return v[7:0];
    endfunction

    // external read-only memory model
    assign nor_rdata = nor_cs_n ? 8'h00 : ext_byte(nor_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] pins);
        @(negedge clk);
        rst_n = 1'b0; mode_pins = pins;
        nf_valid = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cpu_read(input logic [31:0] a, output logic [7:0] d, output logic cs_seen);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #0.1 cs_seen = !nor_cs_n;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [7:0] d, output logic cs_seen);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #0.1 cs_seen = !nor_cs_n;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cpu_rst_n == 1'b0, "R3 reset cpu_rst_n", 32'(cpu_rst_n), 0);
        chk(boot_busy == 1'b0 && boot_done == 1'b0, "R3 reset flags", {boot_busy, boot_done}, 0);
        chk(cpu_rdata == 8'h00, "R11 reset rdata", 32'(cpu_rdata), 0);
    endtask

    task automatic t_copy_boot();
        int  idx = 0;
        bit  pend = 1'b0;
        int  cyc = 0;
        int  stall = 0;
        int  bad = 0;
        logic [7:0] d;
        logic cs;
        do_reset(2'b00);
        @(negedge clk);
        mode_pins = 2'b11; // R2: later strap change must be ignored
        while (idx < 4096) begin
            if (pend) idx++;
            pend = 1'b0;
            if (idx == 4096) break;
            if (idx == 2000 && stall < 20) begin
                stall++;
                nf_valid = 1'b0;
            end else begin
                nf_valid = (cyc % 5) != 3;
            end
            nf_data = flash_byte(idx);
            if (cyc == 100) begin
                chk(boot_busy && !boot_done && !cpu_rst_n, "R3 mid-copy flags",
                    {boot_busy, boot_done, cpu_rst_n}, 3'b100);
            end
            pend = nf_valid && nf_ready;
            cyc++;
            @(negedge clk);
        end
        nf_valid = 1'b0;
        chk(boot_done && !boot_busy && !nf_ready && !cpu_rst_n, "R5 edge after last byte",
            {boot_done, boot_busy, nf_ready, cpu_rst_n}, 4'b1000);
        @(negedge clk);
        chk(cpu_rst_n == 1'b1, "R5 release one cycle later", 32'(cpu_rst_n), 1);
        for (int i = 0; i < 4096; i++) begin
            cpu_read(32'(i), d, cs);
            if (d != flash_byte(i)) begin
                bad++;
                chk(1'b0, "R4 copied byte", {i[15:0], 8'h0, d}, {i[15:0], 8'h0, flash_byte(i)});
            end
        end
        chk(bad == 0, "R4 all 4096 bytes in order", bad, 0);
        cpu_write(32'h0, 8'hA5, cs);
        cpu_write(32'hFFF, 8'h3C, cs);
        cpu_read(32'h0, d, cs);
        chk(d == 8'hA5, "R6 write/read offset 0", 32'(d), 32'hA5);
        cpu_read(32'hFFF, d, cs);
        chk(d == 8'h3C, "R6 write/read offset FFF", 32'(d), 32'h3C);
        cpu_read(32'h1, d, cs);
        chk(d == flash_byte(1), "R6 neighbour untouched", 32'(d), 32'(flash_byte(1)));
        cpu_write(32'h1000, 8'hEE, cs);
        cpu_read(32'h0, d, cs);
        chk(d == 8'hA5, "R7 write above FFF does not alias", 32'(d), 32'hA5);
        cpu_read(32'h1000, d, cs);
        chk(d == 8'h00 && !cs, "R7 read 0x1000", {cs, d}, 0);
        cpu_read(32'h07FF_FFFF, d, cs);
        chk(d == 8'h00 && !cs, "R7 read top of window", {cs, d}, 0);
        cpu_read(32'h0800_0000, d, cs);
        chk(d == 8'h00, "R11 copy mode outside window", 32'(d), 0);
        chk(boot_done && !boot_busy, "R2 mode held after pin change", {boot_done, boot_busy}, 2'b10);
    endtask

    task automatic t_direct_boot(input logic [1:0] pins);
        logic [7:0] d;
        logic cs;
        do_reset(pins);
        nf_valid = 1'b1;
        @(negedge clk);
        mode_pins = 2'b00; // R2: must not switch to copy boot
        chk(boot_done && !cpu_rst_n && !boot_busy && !nf_ready, "R8 first cycle",
            {boot_done, cpu_rst_n, boot_busy, nf_ready}, 4'b1000);
        @(negedge clk);
        chk(cpu_rst_n && !nf_ready && !boot_busy, "R1 R8 released without copy",
            {cpu_rst_n, nf_ready, boot_busy}, 3'b100);
        nf_valid = 1'b0;
        cpu_read(32'h0012_3456, d, cs);
        chk(cs, "R9 chip select on read", 32'(cs), 1);
        chk(d == ext_byte(27'h12_3456), "R9 external read data", 32'(d), 32'(ext_byte(27'h12_3456)));
        cpu_read(32'h0, d, cs);
        chk(d == ext_byte(27'h0), "R9 R2 address 0 is external", 32'(d), 32'(ext_byte(27'h0)));
        cpu_write(32'h0000_0040, 8'hFF, cs);
        chk(!cs, "R10 no chip select on write", 32'(cs), 0);
        cpu_read(32'h0000_0040, d, cs);
        chk(d == ext_byte(27'h40), "R10 contents unchanged", 32'(d), 32'(ext_byte(27'h40)));
        cpu_read(32'h0800_0000, d, cs);
        chk(d == 8'h00 && !cs, "R11 direct mode outside window", {cs, d}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_copy_boot();
        t_direct_boot(2'b01);
        t_direct_boot(2'b10);
        t_direct_boot(2'b11);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule